// File: doc/BRIEF.md
# Five-Channel Input Capture Unit

This block timestamps external events. A free-running up-counter advances once per clock. Each channel watches one event line. The line can be passed through a two-stage synchronizer or only through a single sampling register. It then goes to an edge detector, which reacts to either a rising or a falling edge. When a qualified edge arrives on an enabled channel, the channel copies the counter into its own capture register. The same strobe can set a sticky per-channel status flag, which can in turn drive an interrupt line.

Software sets up each channel through a small word-addressed register port. Writes take effect at the next clock edge. Reads are combinational from the read address. The event lines are plain level inputs with no handshake. An edge that arrives while its channel is disabled is dropped and never replayed. Nothing in the block applies back-pressure, so no valid/ready pair appears at the boundary.

Top module: `multi_capture`

## Requirements
- R1: After synchronous reset, the counter, the capture registers and the enable, edge, sync, status and interrupt-enable registers read 0. The mask register reads all ones (0x1F).
- R2: The counter increases by exactly 1 on every clock outside reset and wraps from all-ones to zero. It is read at address 0x6.
- R3: With edge bit = 1 and sync bit = 0, a 0-to-1 change on the event line that is first sampled at clock edge k loads the capture register at edge k+1 with the counter value present between edges k and k+1.
- R4: With edge bit = 0, only a 1-to-0 change causes a capture, with the same timing as R3. A 0-to-1 change does not.
- R5: With sync bit = 1, the line passes through two flops, and the captured counter value is one count later than in R3.
- R6: A channel whose enable bit is 0 ignores events. Its capture register keeps its last value, or 0 if it has never captured.
- R7: A capture sets the channel's status bit only while its mask bit is 0. With the mask bit at 1, status stays 0.
- R8: Each irq[i] is high exactly while status bit i and interrupt-enable bit i are both 1.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a capture and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: An event on one channel changes no other channel's capture register or status bit.
- R11: Register map, with bit i belonging to channel i. 0x0 is capture enable, 0x1 is edge select (1 = rising), 0x2 is sync select, 0x3 is mask, 0x4 is status (write 1 to clear), 0x5 is interrupt enable. 0x6 is the counter and 0x8+i is channel i's capture register; both are read-only. Control registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and all registers |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | 5 | Event lines, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
The bench measures the exact counter value that gets captured, both with the synchronizer bypassed and with it in use. An off-by-one in either path shows up as a wrong timestamp. It checks that a falling-edge channel ignores rising edges, so a detector with its polarity inverted would capture on the wrong change. It tests the mask reset value and the mask polarity, which catches a status flag that records while masked. It also issues a clear in the same cycle as a capture, so a design that gives priority to the clear loses the event. Separate tests enable one channel and fire another, which catches channels whose enables or status bits are crossed.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CAPEN = 4'h0;
  localparam logic [ADDR_W-1:0] A_EDGE  = 4'h1;
  localparam logic [ADDR_W-1:0] A_SYNC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h4;
  localparam logic [ADDR_W-1:0] A_IRQEN = 4'h5;
  localparam logic [ADDR_W-1:0] A_TIME  = 4'h6;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'h8;
endpackage

// File: rtl/mcap_timebase.sv
module mcap_timebase #(
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] count
);
  // Free-running counter; wraps naturally at all-ones.
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/mcap_channel.sv
module mcap_channel #(
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic          sync_sel,
  input  logic          rise_sel,
  input  logic          cap_en,
  input  logic [TW-1:0] tbc,
  output logic          cap_valid,
  output logic [TW-1:0] cap_val
);
  logic stage1, stage2, prev;
  logic sampled, rise, fall, hit;

  // stage1 alone is the bypass sampler; stage2 completes the synchronizer.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
      prev   <= 1'b0;
    end else begin
      stage1 <= ev;
      stage2 <= stage1;
      prev   <= sampled;
    end
  end

  assign sampled   = sync_sel ? stage2 : stage1;
  assign rise      = sampled & ~prev;
  assign fall      = ~sampled & prev;
  assign hit       = rise_sel ? rise : fall;
  assign cap_valid = hit & cap_en;

  always_ff @(posedge clk) begin
    if (rst)            cap_val <= '0;
    else if (cap_valid) cap_val <= tbc;
  end
endmodule

// File: rtl/mcap_regs.sv
module mcap_regs
  import mcap_pkg::*;
#(
  parameter int unsigned NCH = 5,
  parameter int unsigned TW  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [TW-1:0]           wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [TW-1:0]           rd_data,
  input  logic [NCH-1:0]          cap_valid,
  input  logic [NCH-1:0][TW-1:0]  cap_vals,
  input  logic [TW-1:0]           tbc,
  output logic [NCH-1:0]          cap_en,
  output logic [NCH-1:0]          rise_sel,
  output logic [NCH-1:0]          sync_sel,
  output logic [NCH-1:0]          mask,
  output logic [NCH-1:0]          status,
  output logic [NCH-1:0]          irq_en
);
  logic [NCH-1:0] wbits;
  logic [NCH-1:0] clr_bits;
  logic [NCH-1:0] set_bits;

  assign wbits    = wr_data[NCH-1:0];
  assign clr_bits = (wr_en && wr_addr == A_STAT) ? wbits : '0;
  assign set_bits = cap_valid & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en   <= '0;
      rise_sel <= '0;
      sync_sel <= '0;
      mask     <= '1;
      irq_en   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CAPEN: cap_en   <= wbits;
        A_EDGE:  rise_sel <= wbits;
        A_SYNC:  sync_sel <= wbits;
        A_MASK:  mask     <= wbits;
        A_IRQEN: irq_en   <= wbits;
        default: ;
      endcase
    end
  end

  // Sticky flags: a new capture outranks a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_bits) | set_bits;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CAPEN: rd_data[NCH-1:0] = cap_en;
      A_EDGE:  rd_data[NCH-1:0] = rise_sel;
      A_SYNC:  rd_data[NCH-1:0] = sync_sel;
      A_MASK:  rd_data[NCH-1:0] = mask;
      A_STAT:  rd_data[NCH-1:0] = status;
      A_IRQEN: rd_data[NCH-1:0] = irq_en;
      A_TIME:  rd_data          = tbc;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (rd_addr == A_CAP0 + ADDR_W'(i)) rd_data = cap_vals[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/multi_capture.sv
module multi_capture
  import mcap_pkg::*;
#(
  parameter int unsigned NCH = 5,
  parameter int unsigned TW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ev_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TW-1:0]     rd_data,
  output logic [NCH-1:0]    irq
);
  logic [TW-1:0]          tbc;
  logic [NCH-1:0]         cap_valid;
  logic [NCH-1:0][TW-1:0] cap_vals;
  logic [NCH-1:0]         cap_en, rise_sel, sync_sel, mask, status, irq_en;

  mcap_timebase #(.TW(TW)) u_tb (.clk(clk), .rst(rst), .count(tbc));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mcap_channel #(.TW(TW)) u_ch (
      .clk(clk), .rst(rst), .ev(ev_in[g]),
      .sync_sel(sync_sel[g]), .rise_sel(rise_sel[g]), .cap_en(cap_en[g]),
      .tbc(tbc), .cap_valid(cap_valid[g]), .cap_val(cap_vals[g])
    );
  end

  mcap_regs #(.NCH(NCH), .TW(TW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_valid(cap_valid), .cap_vals(cap_vals), .tbc(tbc),
    .cap_en(cap_en), .rise_sel(rise_sel), .sync_sel(sync_sel),
    .mask(mask), .status(status), .irq_en(irq_en)
  );

  assign irq = status & irq_en;
endmodule

// File: rtl/multi_capture_checker.sv
module multi_capture_checker
  import mcap_pkg::*;
#(
  parameter int unsigned NCH = 5,
  parameter int unsigned TW  = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [TW-1:0]          tbc,
  input logic [NCH-1:0]         cap_valid,
  input logic [NCH-1:0][TW-1:0] cap_vals,
  input logic [NCH-1:0]         mask,
  input logic [NCH-1:0]         status,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [TW-1:0]          wr_data
);
  logic [NCH-1:0] chk_clr;
  logic [NCH-1:0] chk_allowed;
  assign chk_clr     = (wr_en && wr_addr == A_STAT) ? wr_data[NCH-1:0] : '0;
  assign chk_allowed = cap_valid & ~mask;

  // R2: counter steps by one each clock
  p_tbc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tbc == $past(tbc) + 1'b1);

  // R7: a status bit rises only from an unmasked capture
  p_mask_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status & ~$past(status) & ~$past(chk_allowed)) == '0);

  // R9: a status bit falls only on a write-one clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (~status & $past(status) & ~$past(chk_clr)) == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R3: a strobe loads the counter value seen with it
    p_cap_value_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cap_valid[g])) |-> cap_vals[g] == $past(tbc));
    // R6: no strobe, no change
    p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cap_valid[g])) |-> $stable(cap_vals[g]));
  end
endmodule

bind multi_capture multi_capture_checker #(.NCH(NCH), .TW(TW)) u_checker (
  .clk(clk), .rst(rst), .tbc(tbc), .cap_valid(cap_valid), .cap_vals(cap_vals),
  .mask(mask), .status(status), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/multi_capture_test.sv
`timescale 1ns/1ps
module multi_capture_test;
  localparam int NCH = 5;
  localparam int TW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ev_in = '0;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [TW-1:0]  wr_data = '0;
  logic [3:0]     rd_addr = '0;
  logic [TW-1:0]  rd_data;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;

  multi_capture #(.NCH(NCH), .TW(TW)) uut (
    .clk(clk), .rst(rst), .ev_in(ev_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [TW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [TW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; ev_in = '0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Fire one edge on channel ch; return counter value read just before it.
  task automatic fire(input int ch, input logic lvl, output logic [TW-1:0] t);
    rd(4'h6, t);
    ev_in[ch] = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [TW-1:0] v;
    rst = 1'b1; ev_in = '0;
    repeat (2) @(negedge clk);
    rd(4'h6, v); check("R1 counter", v, 0);
    rd(4'h0, v); check("R1 enable", v, 0);
    rd(4'h1, v); check("R1 edge", v, 0);
    rd(4'h2, v); check("R1 sync", v, 0);
    rd(4'h3, v); check("R1 mask", v, 32'h1F);
    rd(4'h4, v); check("R1 status", v, 0);
    rd(4'h5, v); check("R1 irqen", v, 0);
    rd(4'h8, v); check("R1 cap0", v, 0);
    rd(4'hC, v); check("R1 cap4", v, 0);
    check("R1 irq", {27'd0, irq}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_timebase();
    logic [TW-1:0] a, b;
    do_reset();
    rd(4'h6, a);
    @(negedge clk);
    rd(4'h6, b); check("R2 single step", b, a + 1);
    repeat (5) @(negedge clk);
    rd(4'h6, b); check("R2 six steps", b, a + 6);
  endtask

  task automatic t_regmap();
    logic [TW-1:0] v;
    do_reset();
    wr(4'h0, 32'h15); wr(4'h1, 32'h0A); wr(4'h2, 32'h13); wr(4'h5, 32'h06);
    wr(4'h6, 32'hFFFF_0000);
    rd(4'h0, v); check("R11 enable readback", v, 32'h15);
    rd(4'h1, v); check("R11 edge readback", v, 32'h0A);
    rd(4'h2, v); check("R11 sync readback", v, 32'h13);
    rd(4'h5, v); check("R11 irqen readback", v, 32'h06);
    rd(4'h6, v); check("R11 counter not writable", {31'd0, v < 32'h100}, 1);
  endtask

  task automatic t_rise();
    logic [TW-1:0] t, v;
    do_reset();
    wr(4'h0, 32'h02); wr(4'h1, 32'h02);
    fire(1, 1'b1, t);
    rd(4'h9, v); check("R3 rising capture value", v, t + 1);
    rd(4'h4, v); check("R7 masked: no status", v, 0);
  endtask

  task automatic t_fall();
    logic [TW-1:0] t, v;
    do_reset();
    wr(4'h0, 32'h04);
    fire(2, 1'b1, t);
    rd(4'hA, v); check("R4 rising ignored on falling channel", v, 0);
    fire(2, 1'b0, t);
    rd(4'hA, v); check("R4 falling capture value", v, t + 1);
  endtask

  task automatic t_sync();
    logic [TW-1:0] t, v;
    do_reset();
    wr(4'h0, 32'h08); wr(4'h1, 32'h08); wr(4'h2, 32'h08);
    fire(3, 1'b1, t);
    rd(4'hB, v); check("R5 synchronized capture value", v, t + 2);
  endtask

  task automatic t_disable();
    logic [TW-1:0] t, a, v;
    do_reset();
    wr(4'h0, 32'h01); wr(4'h1, 32'h11);
    fire(0, 1'b1, t);
    a = t + 1;
    rd(4'h8, v); check("R6 first capture", v, a);
    wr(4'h0, 32'h00);
    fire(0, 1'b0, t);
    fire(0, 1'b1, t);
    rd(4'h8, v); check("R6 disabled keeps value", v, a);
    fire(4, 1'b1, t);
    rd(4'hC, v); check("R6 never enabled stays zero", v, 0);
  endtask

  task automatic t_mask_irq();
    logic [TW-1:0] t, v;
    do_reset();
    wr(4'h0, 32'h01); wr(4'h1, 32'h01);
    fire(0, 1'b1, t);
    rd(4'h4, v); check("R7 masked capture no status", v, 0);
    wr(4'h3, 32'h1E);
    fire(0, 1'b0, t);
    fire(0, 1'b1, t);
    rd(4'h4, v); check("R7 unmasked capture sets status", v, 32'h01);
    check("R8 irq off while disabled", {27'd0, irq}, 0);
    wr(4'h5, 32'h01);
    check("R8 irq on", {27'd0, irq}, 32'h01);
    wr(4'h4, 32'h00);
    rd(4'h4, v); check("R9 write zero keeps status", v, 32'h01);
    wr(4'h4, 32'h01);
    rd(4'h4, v); check("R9 write one clears", v, 0);
    check("R8 irq off after clear", {27'd0, irq}, 0);
  endtask

  task automatic t_setwins();
    logic [TW-1:0] v;
    do_reset();
    wr(4'h0, 32'h01); wr(4'h1, 32'h01); wr(4'h3, 32'h00);
    ev_in[0] = 1'b1;
    @(negedge clk);
    wr(4'h4, 32'h01);
    @(negedge clk);
    rd(4'h4, v); check("R9 set wins over clear", v, 32'h01);
  endtask

  task automatic t_indep();
    logic [TW-1:0] t, v;
    do_reset();
    wr(4'h0, 32'h14); wr(4'h1, 32'h14); wr(4'h3, 32'h00);
    fire(4, 1'b1, t);
    rd(4'hC, v); check("R10 fired channel captures", v, t + 1);
    rd(4'hA, v); check("R10 other channel untouched", v, 0);
    rd(4'h4, v); check("R10 only own status", v, 32'h10);
  endtask

  initial begin
    #(64'd200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_timebase();
    t_regmap();
    t_rise();
    t_fall();
    t_sync();
    t_disable();
    t_mask_irq();
    t_setwins();
    t_indep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule